// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Controller

This block gives a register port access to a small one-time-programmable fuse store, one 32-bit word at a time. Software selects a word by writing a bank and word index into the control register. It then starts either a sense, which copies the stored word into a result register, or a program, which burns the bits of a data word into the store. While an operation runs, the block raises a busy flag. Each operation walks through three timed phases in a fixed order: a lead relax interval, an active strobe, and a trailing relax interval. The lengths come from a timing register.

The fuse store is modelled inside the block. Its bits can go from 0 to 1 but never back. A program is accepted only while a fixed unlock key sits in the upper half of the control register, and the key is wiped when each program finishes. A request that cannot be honoured sets a sticky error flag. Software clears that flag through a clear alias of the control register.

Top module: `fuse_access_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the timing register reads 0x0006100A (read strobe 6, relax 1, program strobe 10), the sensed-data register reads 0, busy_o is 0 and every fuse word is 0.
- R2: Register offsets on reg_addr_i are: 0 control, 1 control set alias (ORs written bits into the key and address fields), 2 control clear alias (clears written bits of the key, address and error fields), 3 timing, 4 read control, 5 program data, 6 sensed data. Control read layout: key in [31:16], error in [9], busy in [8], word address in [6:0]. Timing layout: read strobe in [21:16], relax in [15:12], program strobe in [11:0]. Reads are combinational from reg_addr_i.
- R3: Writing offset 4 with bit 0 set while idle raises busy_o on the next cycle. When busy_o falls, offset 6 holds the addressed fuse word.
- R4: busy_o stays high for 2·(relax+1)+A cycles, where A = S+1−2·(relax+1) if that is positive and 1 otherwise. S is the read strobe field for a sense and the program strobe field for a program, and both fields are taken when the operation starts.
- R5: strobe_o is high only during the middle A cycles of an operation. It is preceded and followed by relax+1 cycles of busy_o with strobe_o low.
- R6: A program ORs the program-data word into the addressed fuse word, so stored bits only ever go from 0 to 1.
- R7: Writing offset 5 while idle starts a program only if the key field equals 0x3E77. The key field reads 0 after every program completes.
- R8: Writing offset 5 without the key leaves the block idle, leaves the fuse word unchanged and sets the error bit.
- R9: A sense request (offset 4, bit 0) or a program write (offset 5) made while busy_o is high is ignored and sets the error bit. The running operation continues unchanged.
- R10: The error bit stays set until offset 2 is written with bit 9 set. Direct control writes and clear writes without bit 9 leave it set.
- R11: The word address is bank·8+word, which covers 16 banks of 8 words. A program changes only the addressed word.
- R12: Writing offset 4 with bit 0 clear starts nothing and leaves the error bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| busy_o | output | 1 | Operation in progress |
| strobe_o | output | 1 | Active strobe phase of the running operation |

## Verification
A write is taken at the clock edge where reg_we_i is high. A started operation shows busy_o after that same edge, and strobe_o rises relax+1 edges later. The sensed word, the fuse update and the key wipe all land on the edge where busy_o falls, 2·(relax+1)+A edges after the start, and an error flag appears one edge after the rejected write. A behavioural model in the bench advances on every rising edge from the same inputs. busy_o and strobe_o are compared with it at each falling edge, and register reads are sampled one time step after the offset is driven in mid-cycle, so every comparison lands after the register that produces it has settled.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned KEY_W    = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;
  localparam int unsigned BUSY_BIT = 8;
  localparam int unsigned ERR_BIT  = 9;
  localparam int unsigned AFIELD_W = 7;
  localparam int unsigned RDS_W    = 6;
  localparam int unsigned RLX_W    = 4;
  localparam int unsigned PGS_W    = 12;
  localparam logic [RDS_W-1:0] RDS_RST = 6'd6;
  localparam logic [RLX_W-1:0] RLX_RST = 4'd1;
  localparam logic [PGS_W-1:0] PGS_RST = 12'd10;

  typedef enum logic [2:0] {
    OFF_CTRL   = 3'd0,
    OFF_SET    = 3'd1,
    OFF_CLR    = 3'd2,
    OFF_TIMING = 3'd3,
    OFF_RDCTL  = 3'd4,
    OFF_PDATA  = 3'd5,
    OFF_SENSED = 3'd6
  } reg_off_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_FIRE,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_prog_i,
  output logic [KEY_W-1:0]  unlock_o,
  output logic [AW-1:0]     word_addr_o,
  output logic              err_o,
  output logic [RDS_W-1:0]  rd_strobe_o,
  output logic [RLX_W-1:0]  relax_o,
  output logic [PGS_W-1:0]  pg_strobe_o,
  output logic [REG_DW-1:0] pdata_o,
  output logic              start_sense_o,
  output logic              start_prog_o
);
  logic [KEY_W-1:0] unlock_q, unlock_base, wkey;
  logic [AW-1:0]    waddr_q, wa;
  logic             err_q, err_set, err_clr;
  logic             sense_req, prog_req;

  assign wkey = wdata_i[REG_DW-1:REG_DW-KEY_W];
  assign wa   = wdata_i[AW-1:0];

  assign sense_req = we_i && (addr_i == OFF_RDCTL) && wdata_i[0];
  assign prog_req  = we_i && (addr_i == OFF_PDATA);

  assign start_sense_o = sense_req && !busy_i;
  assign start_prog_o  = prog_req && !busy_i && (unlock_q == UNLOCK_KEY);

  // rejected request: busy, or program without key
  assign err_set = (sense_req && busy_i) ||
                   (prog_req && (busy_i || unlock_q != UNLOCK_KEY));
  assign err_clr = we_i && (addr_i == OFF_CLR) && wdata_i[ERR_BIT];

  // completion wipes the key before any same-cycle write applies
  assign unlock_base = done_prog_i ? '0 : unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q    <= '0;
      waddr_q     <= '0;
      err_q       <= 1'b0;
      rd_strobe_o <= RDS_RST;
      relax_o     <= RLX_RST;
      pg_strobe_o <= PGS_RST;
      pdata_o     <= '0;
    end else begin
      unlock_q <= unlock_base;
      if (we_i) begin
        unique case (addr_i)
          OFF_CTRL: begin
            unlock_q <= wkey;
            waddr_q  <= wa;
          end
          OFF_SET: begin
            unlock_q <= unlock_base | wkey;
            waddr_q  <= waddr_q | wa;
          end
          OFF_CLR: begin
            unlock_q <= unlock_base & ~wkey;
            waddr_q  <= waddr_q & ~wa;
          end
          OFF_TIMING: begin
            rd_strobe_o <= wdata_i[16 +: RDS_W];
            relax_o     <= wdata_i[12 +: RLX_W];
            pg_strobe_o <= wdata_i[0 +: PGS_W];
          end
          OFF_PDATA: if (start_prog_o) pdata_o <= wdata_i;
          default: ;
        endcase
      end
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign unlock_o    = unlock_q;
  assign word_addr_o = waddr_q;
  assign err_o       = err_q;
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_sense_i,
  input  logic             start_prog_i,
  input  logic [RDS_W-1:0] rd_strobe_i,
  input  logic [RLX_W-1:0] relax_i,
  input  logic [PGS_W-1:0] pg_strobe_i,
  input  logic [AW-1:0]    word_addr_i,
  output logic             busy_o,
  output logic             strobe_o,
  output logic             done_o,
  output logic             done_prog_o,
  output logic [AW-1:0]    op_addr_o
);
  localparam int unsigned CW = PGS_W + 1;

  phase_e           phase_q;
  logic [CW-1:0]    cnt_q;
  logic [RLX_W-1:0] relax_q;
  logic [CW-1:0]    act_q;
  logic             prog_q;
  logic [PGS_W-1:0] sel;
  logic [CW-1:0]    total, two_relax, act_len;
  logic             start;

  assign start     = start_sense_i || start_prog_i;
  assign sel       = start_prog_i ? pg_strobe_i : PGS_W'(rd_strobe_i);
  assign total     = CW'(sel) + CW'(1);
  assign two_relax = (CW'(relax_i) + CW'(1)) << 1;
  // strobe count already covers both relax phases
  assign act_len   = (total > two_relax) ? (total - two_relax) : CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      relax_q   <= '0;
      act_q     <= '0;
      prog_q    <= 1'b0;
      op_addr_o <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q   <= PH_LEAD;
          cnt_q     <= CW'(relax_i);
          relax_q   <= relax_i;
          act_q     <= act_len - CW'(1);
          prog_q    <= start_prog_i;
          op_addr_o <= word_addr_i;
        end
        PH_LEAD: if (cnt_q == '0) begin
          phase_q <= PH_FIRE;
          cnt_q   <= act_q;
        end else cnt_q <= cnt_q - CW'(1);
        PH_FIRE: if (cnt_q == '0) begin
          phase_q <= PH_TAIL;
          cnt_q   <= CW'(relax_q);
        end else cnt_q <= cnt_q - CW'(1);
        PH_TAIL: if (cnt_q == '0) phase_q <= PH_IDLE;
                 else cnt_q <= cnt_q - CW'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign strobe_o    = (phase_q == PH_FIRE);
  assign done_o      = (phase_q == PH_TAIL) && (cnt_q == '0);
  assign done_prog_o = done_o && prog_q;
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int unsigned NWORDS = 128,
  parameter int unsigned AW     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              done_prog_i,
  input  logic [AW-1:0]     op_addr_i,
  input  logic [REG_DW-1:0] pdata_i,
  output logic [REG_DW-1:0] sensed_o
);
  logic [REG_DW-1:0] rows [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_row
    logic [REG_DW-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q <= '0;
      else if (done_prog_i && op_addr_i == AW'(g)) row_q <= row_q | pdata_i;
    end
    assign rows[g] = row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sensed_o <= '0;
    else if (done_i && !done_prog_i) sensed_o <= rows[op_addr_i];
  end
endmodule

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl
  import fuse_pkg::*;
#(
  parameter int unsigned BANKS          = 16,
  parameter int unsigned WORDS_PER_BANK = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              busy_o,
  output logic              strobe_o
);
  localparam int unsigned NWORDS = BANKS * WORDS_PER_BANK;
  localparam int unsigned AW     = $clog2(NWORDS);

  logic [KEY_W-1:0]  ctrl_unlock;
  logic [AW-1:0]     ctrl_addr, op_addr;
  logic              ctrl_err;
  logic [RDS_W-1:0]  rd_strobe;
  logic [RLX_W-1:0]  relax;
  logic [PGS_W-1:0]  pg_strobe;
  logic [REG_DW-1:0] pdata, sensed;
  logic              start_sense, start_prog, done, done_prog;
  logic [REG_DW-1:0] ctrl_view;

  fuse_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .busy_i        (busy_o),
    .done_prog_i   (done_prog),
    .unlock_o      (ctrl_unlock),
    .word_addr_o   (ctrl_addr),
    .err_o         (ctrl_err),
    .rd_strobe_o   (rd_strobe),
    .relax_o       (relax),
    .pg_strobe_o   (pg_strobe),
    .pdata_o       (pdata),
    .start_sense_o (start_sense),
    .start_prog_o  (start_prog)
  );

  fuse_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .start_sense_i (start_sense),
    .start_prog_i  (start_prog),
    .rd_strobe_i   (rd_strobe),
    .relax_i       (relax),
    .pg_strobe_i   (pg_strobe),
    .word_addr_i   (ctrl_addr),
    .busy_o        (busy_o),
    .strobe_o      (strobe_o),
    .done_o        (done),
    .done_prog_o   (done_prog),
    .op_addr_o     (op_addr)
  );

  fuse_array #(.NWORDS(NWORDS), .AW(AW)) u_array (
    .clk_i, .rst_ni,
    .done_i      (done),
    .done_prog_i (done_prog),
    .op_addr_i   (op_addr),
    .pdata_i     (pdata),
    .sensed_o    (sensed)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[REG_DW-1 -: KEY_W] = ctrl_unlock;
    ctrl_view[ERR_BIT]           = ctrl_err;
    ctrl_view[BUSY_BIT]          = busy_o;
    ctrl_view[AW-1:0]            = ctrl_addr;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL, OFF_SET, OFF_CLR: reg_rdata_o = ctrl_view;
      OFF_TIMING: reg_rdata_o = {10'd0, rd_strobe, relax, pg_strobe};
      OFF_PDATA:  reg_rdata_o = pdata;
      OFF_SENSED: reg_rdata_o = sensed;
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fuse_access_ctrl_chk.sv
module fuse_access_ctrl_chk
  import fuse_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [REG_DW-1:0] wdata_i,
  input logic              busy_i,
  input logic              strobe_i,
  input logic              err_i,
  input logic [KEY_W-1:0]  unlock_i
);
  a_r3_sense_starts_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_RDCTL && wdata_i[0] && !busy_i) |=> busy_i);

  a_r4_lead_before_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !strobe_i);

  a_r5_strobe_inside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> busy_i);

  a_r5_tail_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_i) |-> busy_i);

  a_r8_keyless_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_PDATA && !busy_i && unlock_i != UNLOCK_KEY) |=> (!busy_i && err_i));

  a_r9_busy_request_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && busy_i && (addr_i == OFF_PDATA || (addr_i == OFF_RDCTL && wdata_i[0]))) |=> err_i);

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(we_i && addr_i == OFF_CLR && wdata_i[ERR_BIT])) |=> err_i);
endmodule

bind fuse_access_ctrl fuse_access_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .busy_i   (busy_o),
  .strobe_i (strobe_o),
  .err_i    (ctrl_err),
  .unlock_i (ctrl_unlock)
);

// File: tb/fuse_access_ctrl_test.sv
module fuse_access_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, strobe;

  always #4 clk = ~clk;

  fuse_access_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy), .strobe_o(strobe)
  );

  int n_chk = 0, n_fail = 0;

  // behavioural reference
  logic [31:0] m_fuse [128];
  logic [15:0] m_unlock;
  logic [6:0]  m_afield, m_addr;
  logic        m_err, m_prog, m_on;
  logic [31:0] m_sensed, m_pdata;
  logic [5:0]  m_rs;
  logic [3:0]  m_rx;
  logic [11:0] m_ps;
  int          m_left, m_el, m_lead, m_act;

  task automatic m_start(bit prog);
    int total;
    total  = (prog ? int'(m_ps) : int'(m_rs)) + 1;
    m_lead = int'(m_rx) + 1;
    m_act  = (total > 2 * m_lead) ? total - 2 * m_lead : 1;
    m_left = 2 * m_lead + m_act;
    m_el   = 0;
    m_prog = prog;
    m_addr = m_afield;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 128; i++) m_fuse[i] = '0;
      m_unlock = '0; m_afield = '0; m_addr = '0; m_err = 0; m_prog = 0;
      m_sensed = '0; m_pdata = '0; m_rs = 6'd6; m_rx = 4'd1; m_ps = 12'd10;
      m_left = 0; m_el = 0; m_lead = 0; m_act = 0;
    end else begin
      bit busy_pre;
      logic [15:0] key_pre;
      busy_pre = (m_left > 0);
      key_pre  = m_unlock;
      if (busy_pre) begin
        m_el++; m_left--;
        if (m_left == 0) begin
          if (m_prog) begin
            m_fuse[m_addr] = m_fuse[m_addr] | m_pdata;
            m_unlock = '0;
          end else m_sensed = m_fuse[m_addr];
        end
      end
      if (we) begin
        case (addr)
          3'd0: begin m_unlock = wdata[31:16]; m_afield = wdata[6:0]; end
          3'd1: begin m_unlock |= wdata[31:16]; m_afield |= wdata[6:0]; end
          3'd2: begin
            m_unlock &= ~wdata[31:16]; m_afield &= ~wdata[6:0];
            if (wdata[9]) m_err = 0;
          end
          3'd3: begin m_rs = wdata[21:16]; m_rx = wdata[15:12]; m_ps = wdata[11:0]; end
          3'd4: if (wdata[0]) begin
            if (busy_pre) m_err = 1; else m_start(0);
          end
          3'd5: begin
            if (busy_pre || key_pre != 16'h3E77) m_err = 1;
            else begin m_pdata = wdata; m_start(1); end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_on) begin
      chk("R4 busy_o per cycle", 32'(busy), 32'(m_left > 0));
      chk("R5 strobe_o per cycle", 32'(strobe),
          32'((m_left > 0) && m_el >= m_lead && m_el < m_lead + m_act));
    end
  end

  function automatic logic [31:0] ctrl_exp();
    return {m_unlock, 6'd0, m_err, (m_left > 0), 1'b0, m_afield};
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic sense(logic [6:0] wa);
    wr(3'd0, {16'd0, 9'd0, wa});
    wr(3'd4, 32'd1);
    wait_idle();
  endtask

  task automatic prog(logic [6:0] wa, logic [31:0] d);
    wr(3'd0, {16'h3E77, 9'd0, wa});
    wr(3'd5, d);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    m_on = 1'b1;
    @(negedge clk);
    // R1
    rd("R1 control reset", 3'd0, 32'h0);
    rd("R1 timing reset", 3'd3, 32'h0006100A);
    rd("R1 sensed reset", 3'd6, 32'h0);
    chk("R1 busy reset", 32'(busy), 32'h0);
    // R2 field layout and aliases
    wr(3'd0, 32'h1234_001D);
    rd("R2 control readback", 3'd0, 32'h1234_001D);
    wr(3'd1, 32'h0001_0062);
    rd("R2 set alias", 3'd0, 32'h1235_007F);
    wr(3'd2, 32'h1235_0070);
    rd("R2 clear alias", 3'd2, 32'h0000_000F);
    // R1/R3 sense of blank word, default timing
    sense(7'd29);
    rd("R3 sensed blank", 3'd6, 32'h0);
    // R6 R7 program
    prog(7'd29, 32'h0000_00F0);
    rd("R7 key wiped", 3'd0, ctrl_exp());
    chk("R7 key field zero", rdata[31:16], 32'h0);
    sense(7'd29);
    rd("R6 programmed value", 3'd6, 32'h0000_00F0);
    prog(7'd29, 32'h0F00_0001);
    sense(7'd29);
    rd("R6 OR accumulation", 3'd6, 32'h0F00_00F1);
    // R8 program without key
    wr(3'd0, {16'h3E76, 16'd29});
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R8 stays idle", 32'(busy), 32'h0);
    rd("R8 error set", 3'd0, ctrl_exp());
    chk("R8 error bit", 32'(rdata[9]), 32'h1);
    sense(7'd29);
    rd("R8 fuse unchanged", 3'd6, 32'h0F00_00F1);
    // R10 sticky error
    wr(3'd0, 32'h0000_021D);
    rd("R10 direct write keeps error", 3'd0, 32'h0000_021D);
    wr(3'd2, 32'h0000_0100);
    rd("R10 clear without bit9 keeps error", 3'd0, 32'h0000_021D);
    wr(3'd2, 32'h0000_0200);
    rd("R10 clear bit9", 3'd0, 32'h0000_001D);
    // R9 request while busy
    wr(3'd4, 32'd1);
    wr(3'd4, 32'd1);
    wr(3'd5, 32'hFFFF_FFFF);
    rd("R9 error while busy", 3'd0, ctrl_exp());
    chk("R9 error bit", 32'(rdata[9]), 32'h1);
    wait_idle();
    rd("R9 original sense completes", 3'd6, 32'h0F00_00F1);
    wr(3'd2, 32'h0000_0200);
    // R11 addressing corners
    prog(7'd127, 32'hA5A5_0000);
    prog(7'd0, 32'h0000_5A5A);
    sense(7'd127);
    rd("R11 bank15 word7", 3'd6, 32'hA5A5_0000);
    sense(7'd0);
    rd("R11 bank0 word0", 3'd6, 32'h0000_5A5A);
    sense(7'd8);
    rd("R11 bank1 word0 untouched", 3'd6, 32'h0);
    sense(7'd29);
    rd("R11 bank3 word5 untouched", 3'd6, 32'h0F00_00F1);
    // R4 R5 other timings: long strobe, then strobe shorter than relax span
    wr(3'd3, 32'h0014_3000 | 32'd30);
    rd("R2 timing readback", 3'd3, 32'h0014_301E);
    sense(7'd127);
    rd("R4 long read strobe result", 3'd6, 32'hA5A5_0000);
    prog(7'd64, 32'h0000_0003);
    wr(3'd3, 32'h0002_2002);
    sense(7'd64);
    rd("R4 minimum active phase result", 3'd6, 32'h0000_0003);
    // R12 read-control write without bit 0
    wr(3'd4, 32'hFFFF_FFFE);
    chk("R12 no start", 32'(busy), 32'h0);
    rd("R12 no error", 3'd0, ctrl_exp());
    chk("R12 error clear", 32'(rdata[9]), 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule